// File: doc/BRIEF.md
# Multi-Channel Word DMA Engine

This block is a register-programmed DMA controller with a parameterized number of channels (8 or 16). Software writes a channel's source and destination byte addresses and two control words through a 32-bit register port. Setting the enable bit of control word 0 starts the channel. A single shared mover copies 32-bit words from source to destination over a simple word-wide memory port. Each grant moves one burst, whose size is picked by a 3-bit code. Either side's address can be held constant, which suits a peripheral data register.

When a channel's byte count runs out, the engine clears that channel's enable bit and sets its bit in a write-one-to-clear done register. The interrupt output combines the done bits with a per-channel unmask register and the channel's own interrupt-enable bit. A global register selects between lowest-index priority and round-robin arbitration, and reports a version number and the channel count. Register reads return data one cycle after the read strobe.

The memory port has no stall: a read strobe returns data on the following cycle, and a write strobe is accepted at once.

Top module: `mcdma_top`

## Requirements
- R1: Channel `c` owns four registers at byte offset `0x10*c`: source address at +0x0, destination address at +0x4, control word 0 at +0x8 and control word 1 at +0xC. Every one of them reads back what was last written, except where the engine updates it. `reg_rdata` holds the read value from the cycle after `reg_rd_en`.
- R2: Each word moved is read from the channel's current source address and written unchanged to its current destination address. After each word, the source address advances by 4 unless control-word-0 bit 7 is set, and the destination address advances by 4 unless bit 6 is set.
- R3: Control-word-0 bits 31:16 give the byte count. The engine moves floor(count/4) words and lowers the field by 4 for each word moved. It never moves a word when fewer than 4 bytes remain.
- R4: Control-word-0 bits 5:3 are the burst code: 0, 1, 2, 3 and 4 give bursts of 1, 2, 4, 8 and 16 words, and codes 5 to 7 act as 16 words. A burst that would overrun the count is cut short to the words that remain.
- R5: When fewer than 4 bytes remain, the engine clears the enable bit (control-word-0 bit 1) and sets the channel's bit in the done register at 0x204. A channel enabled with a count below 4 completes in this way without moving any data.
- R6: Writing the done register clears exactly the bits written as 1. Bits written as 0 keep their value.
- R7: `irq` is a registered OR over all channels of (done bit AND unmask bit AND control-word-0 bit 2). The unmask register is at 0x200 and has one bit per channel.
- R8: Each grant covers one burst. When bit 0 of the global register at 0x220 is 0, the lowest-numbered enabled channel wins. When it is 1, the search starts at the channel after the last one granted and wraps around.
- R9: Reading the global register returns bit 0 as written, the VERSION parameter in bits 2:1, and log2(channels/8) in bits 4:3. All other bits read as 0.
- R10: Writing control word 0 with bit 1 clear stops an active channel. At most the one word already issued is written after the stop, the done bit is not set, and the engine then serves other channels normally.
- R11: After reset, all registers read 0 except the global register, which shows only its constant fields. `irq`, `mem_rd_en` and `mem_wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after the read strobe |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | 32 | Memory read byte address |
| mem_rd_data | input | 32 | Memory read data, valid the cycle after the strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | 32 | Memory write byte address |
| mem_wr_data | output | 32 | Memory write data |
| irq | output | 1 | Combined completion interrupt |

## Verification
The hardest case to reach is arbitration among several channels that are ready at the same moment. Software can only enable channels one register write at a time, and an idle engine grabs the first enabled channel at once. The bench handles this by starting a long 16-word-burst channel first and enabling two more channels while that first burst is still running. All three then compete at the burst boundary, and the exact order of written addresses is predicted for fixed priority and again for round-robin. Stopping a channel mid-transfer is checked by counting memory writes after the stop instead of predicting them one by one.

// File: rtl/mcdma_pkg.sv
package mcdma_pkg;

  // control word 0 bit positions
  localparam int CW0_SRC_HOLD = 7;
  localparam int CW0_DST_HOLD = 6;
  localparam int CW0_IRQ_EN   = 2;
  localparam int CW0_RUN      = 1;

  // global register byte offsets
  localparam int OFS_UNMASK = 'h200;
  localparam int OFS_DONE   = 'h204;
  localparam int OFS_GLOBAL = 'h220;

  typedef enum logic [1:0] {MV_IDLE, MV_RD, MV_WR} mv_state_t;

  // burst code to words per burst
  function automatic logic [4:0] burst_words(input logic [2:0] code);
    case (code)
      3'd0:    burst_words = 5'd1;
      3'd1:    burst_words = 5'd2;
      3'd2:    burst_words = 5'd4;
      3'd3:    burst_words = 5'd8;
      default: burst_words = 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/mcdma_arb.sv
module mcdma_arb #(
  parameter int NCH = 8,
  parameter int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] req,
  input  logic           rr_mode,
  input  logic           take,
  output logic           gnt_valid,
  output logic [CHW-1:0] gnt_ch
);

  logic [CHW-1:0] last_q;
  logic [CHW-1:0] start;
  logic [CHW-1:0] idx;

  always_comb begin
    start     = rr_mode ? last_q + 1'b1 : '0;
    gnt_valid = 1'b0;
    gnt_ch    = '0;
    idx       = '0;
    for (int k = 0; k < NCH; k++) begin
      idx = start + CHW'(k);
      if (!gnt_valid && req[idx]) begin
        gnt_valid = 1'b1;
        gnt_ch    = idx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) last_q <= CHW'(NCH - 1);
    else if (take) last_q <= gnt_ch;
  end

  assert_gnt_ready_R8: assert property (@(posedge clk) disable iff (rst)
    gnt_valid |-> req[gnt_ch]);

  assert_take_valid_R8: assert property (@(posedge clk) disable iff (rst)
    take |-> gnt_valid);

endmodule

// File: rtl/mcdma_regs.sv
module mcdma_regs
  import mcdma_pkg::*;
#(
  parameter int NCH     = 8,
  parameter int VERSION = 2,
  parameter int ADDR_W  = 10,
  parameter int CHW     = $clog2(NCH)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_wr_en,
  input  logic                  reg_rd_en,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  input  logic                  upd_en,
  input  logic [CHW-1:0]        upd_ch,
  input  logic [31:0]           upd_src,
  input  logic [31:0]           upd_dst,
  input  logic [15:0]           upd_len,
  input  logic                  upd_finish,
  output logic [NCH-1:0][31:0]  src_q,
  output logic [NCH-1:0][31:0]  dst_q,
  output logic [NCH-1:0][31:0]  cw0_q,
  output logic                  rr_mode,
  output logic                  irq
);

  localparam logic [ADDR_W-1:0] A_UNMASK = ADDR_W'(OFS_UNMASK);
  localparam logic [ADDR_W-1:0] A_DONE   = ADDR_W'(OFS_DONE);
  localparam logic [ADDR_W-1:0] A_GLOBAL = ADDR_W'(OFS_GLOBAL);
  localparam logic [1:0]        CNT_CODE = 2'($clog2(NCH / 8));
  localparam logic [1:0]        VER_CODE = 2'(VERSION);

  logic [NCH-1:0][31:0] cw1_q;
  logic [NCH-1:0]       unmask_q, done_q, ien_vec;
  logic [NCH-1:0]       hit_src, hit_dst, hit_cw0, hit_cw1, upd_sel;
  logic [NCH-1:0]       done_set, done_clr;
  logic                 ch_area;
  logic [CHW-1:0]       acc_ch;
  logic [1:0]           fld;
  logic                 unused_bits;

  assign ch_area     = (reg_addr[ADDR_W-1:4] < (ADDR_W-4)'(NCH));
  assign acc_ch      = reg_addr[4 +: CHW];
  assign fld         = reg_addr[3:2];
  assign unused_bits = ^reg_addr[1:0];

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      hit_src[i]  = reg_wr_en && ch_area && acc_ch == CHW'(i) && fld == 2'd0;
      hit_dst[i]  = reg_wr_en && ch_area && acc_ch == CHW'(i) && fld == 2'd1;
      hit_cw0[i]  = reg_wr_en && ch_area && acc_ch == CHW'(i) && fld == 2'd2;
      hit_cw1[i]  = reg_wr_en && ch_area && acc_ch == CHW'(i) && fld == 2'd3;
      upd_sel[i]  = upd_en && upd_ch == CHW'(i);
      done_set[i] = upd_sel[i] && upd_finish;
      ien_vec[i]  = cw0_q[i][CW0_IRQ_EN];
    end
    done_clr = (reg_wr_en && reg_addr == A_DONE) ? reg_wdata[NCH-1:0] : '0;
  end

  // channel registers: a software write wins over an engine update
  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= '0;
      dst_q <= '0;
      cw0_q <= '0;
      cw1_q <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (hit_src[i])      src_q[i] <= reg_wdata;
        else if (upd_sel[i]) src_q[i] <= upd_src;
        if (hit_dst[i])      dst_q[i] <= reg_wdata;
        else if (upd_sel[i]) dst_q[i] <= upd_dst;
        if (hit_cw0[i]) cw0_q[i] <= reg_wdata;
        else if (upd_sel[i]) begin
          cw0_q[i][31:16] <= upd_len;
          if (upd_finish) cw0_q[i][CW0_RUN] <= 1'b0;
        end
        if (hit_cw1[i]) cw1_q[i] <= reg_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q   <= '0;
      unmask_q <= '0;
      rr_mode  <= 1'b0;
      irq      <= 1'b0;
    end else begin
      done_q <= (done_q & ~done_clr) | done_set;
      if (reg_wr_en && reg_addr == A_UNMASK) unmask_q <= reg_wdata[NCH-1:0];
      if (reg_wr_en && reg_addr == A_GLOBAL) rr_mode <= reg_wdata[0];
      irq <= |(done_q & unmask_q & ien_vec);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd_en) begin
      reg_rdata <= '0;
      if (ch_area) begin
        case (fld)
          2'd0:    reg_rdata <= src_q[acc_ch];
          2'd1:    reg_rdata <= dst_q[acc_ch];
          2'd2:    reg_rdata <= cw0_q[acc_ch];
          default: reg_rdata <= cw1_q[acc_ch];
        endcase
      end else if (reg_addr == A_UNMASK) reg_rdata <= 32'(unmask_q);
      else if (reg_addr == A_DONE)       reg_rdata <= 32'(done_q);
      else if (reg_addr == A_GLOBAL)     reg_rdata <= {27'd0, CNT_CODE, VER_CODE, rr_mode};
    end
  end

  assert_src_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (upd_en && cw0_q[upd_ch][CW0_SRC_HOLD]) |-> (upd_src == src_q[upd_ch]));

  assert_dst_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (upd_en && cw0_q[upd_ch][CW0_DST_HOLD]) |-> (upd_dst == dst_q[upd_ch]));

  assert_finish_posts_R5: assert property (@(posedge clk) disable iff (rst)
    (upd_en && upd_finish && !hit_cw0[upd_ch])
      |=> (done_q[$past(upd_ch)] && !cw0_q[$past(upd_ch)][CW0_RUN]));

endmodule

// File: rtl/mcdma_mover.sv
module mcdma_mover
  import mcdma_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CHW = $clog2(NCH)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NCH-1:0][31:0] src_q,
  input  logic [NCH-1:0][31:0] dst_q,
  input  logic [NCH-1:0][31:0] cw0_q,
  input  logic                 gnt_valid,
  input  logic [CHW-1:0]       gnt_ch,
  output logic                 take,
  output logic                 mem_rd_en,
  output logic [31:0]          mem_rd_addr,
  input  logic [31:0]          mem_rd_data,
  output logic                 mem_wr_en,
  output logic [31:0]          mem_wr_addr,
  output logic [31:0]          mem_wr_data,
  output logic                 upd_en,
  output logic [CHW-1:0]       upd_ch,
  output logic [31:0]          upd_src,
  output logic [31:0]          upd_dst,
  output logic [15:0]          upd_len,
  output logic                 upd_finish
);

  mv_state_t      state;
  logic [CHW-1:0] cur;
  logic [4:0]     left;
  logic [31:0]    cur_cw0, g_cw0, nxt_src, nxt_dst;
  logic [15:0]    cur_len, g_len, nxt_len;
  logic [13:0]    g_avail;
  logic [4:0]     g_bw, g_first;
  logic           cur_en, idle_zero, wr_step, last_word;
  logic           unused_bits;

  assign unused_bits = ^cw0_q;

  always_comb begin
    cur_cw0   = cw0_q[cur];
    cur_en    = cur_cw0[CW0_RUN];
    cur_len   = cur_cw0[31:16];
    g_cw0     = cw0_q[gnt_ch];
    g_len     = g_cw0[31:16];
    g_avail   = g_len[15:2];
    g_bw      = burst_words(g_cw0[5:3]);
    g_first   = (g_avail < {9'd0, g_bw}) ? g_avail[4:0] : g_bw;
    nxt_src   = cur_cw0[CW0_SRC_HOLD] ? src_q[cur] : src_q[cur] + 32'd4;
    nxt_dst   = cur_cw0[CW0_DST_HOLD] ? dst_q[cur] : dst_q[cur] + 32'd4;
    nxt_len   = cur_len - 16'd4;
    last_word = nxt_len < 16'd4;
    take      = (state == MV_IDLE) && gnt_valid;
    idle_zero = take && (g_len < 16'd4);
    wr_step   = (state == MV_WR) && cur_en;
    upd_en    = idle_zero || wr_step;
    upd_ch    = (state == MV_IDLE) ? gnt_ch : cur;
    upd_src   = idle_zero ? src_q[gnt_ch] : nxt_src;
    upd_dst   = idle_zero ? dst_q[gnt_ch] : nxt_dst;
    upd_len   = idle_zero ? g_len : nxt_len;
    upd_finish = idle_zero || last_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= MV_IDLE;
      cur         <= '0;
      left        <= '0;
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
      mem_wr_en   <= 1'b0;
      mem_wr_addr <= '0;
      mem_wr_data <= '0;
    end else begin
      mem_rd_en <= 1'b0;
      mem_wr_en <= 1'b0;
      case (state)
        MV_IDLE: begin
          if (take && !idle_zero) begin
            cur         <= gnt_ch;
            left        <= g_first;
            mem_rd_en   <= 1'b1;
            mem_rd_addr <= src_q[gnt_ch];
            state       <= MV_RD;
          end
        end
        MV_RD: state <= MV_WR;
        default: begin
          state <= MV_IDLE;
          if (cur_en) begin
            mem_wr_en   <= 1'b1;
            mem_wr_addr <= dst_q[cur];
            mem_wr_data <= mem_rd_data;
            if (left > 5'd1 && !last_word) begin
              left        <= left - 5'd1;
              mem_rd_en   <= 1'b1;
              mem_rd_addr <= nxt_src;
              state       <= MV_RD;
            end
          end
        end
      endcase
    end
  end

  assert_wr_after_rd_R2: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> $past(mem_rd_en, 2));

  assert_no_overrun_R3: assert property (@(posedge clk) disable iff (rst)
    (state == MV_WR && cur_en) |-> (cur_len >= 16'd4));

  assert_burst_bound_R4: assert property (@(posedge clk) disable iff (rst)
    (state == MV_RD) |-> (left != 5'd0 && left <= 5'd16));

endmodule

// File: rtl/mcdma_top.sv
module mcdma_top #(
  parameter int NCH     = 8,
  parameter int VERSION = 2,
  parameter int ADDR_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_rd_en,
  output logic [31:0]       mem_rd_addr,
  input  logic [31:0]       mem_rd_data,
  output logic              mem_wr_en,
  output logic [31:0]       mem_wr_addr,
  output logic [31:0]       mem_wr_data,
  output logic              irq
);

  localparam int CHW = $clog2(NCH);

  logic [NCH-1:0][31:0] src_q, dst_q, cw0_q;
  logic [NCH-1:0]       req;
  logic                 rr_mode, gnt_valid, take;
  logic [CHW-1:0]       gnt_ch, upd_ch;
  logic                 upd_en, upd_finish;
  logic [31:0]          upd_src, upd_dst;
  logic [15:0]          upd_len;

  always_comb begin
    for (int i = 0; i < NCH; i++) req[i] = cw0_q[i][mcdma_pkg::CW0_RUN];
  end

  mcdma_regs #(.NCH(NCH), .VERSION(VERSION), .ADDR_W(ADDR_W), .CHW(CHW)) u_regs (
    .clk(clk), .rst(rst),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .upd_en(upd_en), .upd_ch(upd_ch), .upd_src(upd_src), .upd_dst(upd_dst),
    .upd_len(upd_len), .upd_finish(upd_finish),
    .src_q(src_q), .dst_q(dst_q), .cw0_q(cw0_q),
    .rr_mode(rr_mode), .irq(irq)
  );

  mcdma_arb #(.NCH(NCH), .CHW(CHW)) u_arb (
    .clk(clk), .rst(rst), .req(req), .rr_mode(rr_mode), .take(take),
    .gnt_valid(gnt_valid), .gnt_ch(gnt_ch)
  );

  mcdma_mover #(.NCH(NCH), .CHW(CHW)) u_mover (
    .clk(clk), .rst(rst),
    .src_q(src_q), .dst_q(dst_q), .cw0_q(cw0_q),
    .gnt_valid(gnt_valid), .gnt_ch(gnt_ch), .take(take),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .upd_en(upd_en), .upd_ch(upd_ch), .upd_src(upd_src), .upd_dst(upd_dst),
    .upd_len(upd_len), .upd_finish(upd_finish)
  );

endmodule

// File: tb/mcdma_top_test.sv
module mcdma_top_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [9:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_rd_en, mem_wr_en, irq;
  logic [31:0] mem_rd_addr, mem_wr_addr, mem_wr_data;
  logic [31:0] mem_rd_data = '0;

  int compared = 0;
  int mismatched = 0;
  int wr_count = 0;
  bit sb_on = 1'b1;
  bit finished = 1'b0;

  typedef struct {logic [31:0] addr; logic [31:0] data; int req;} item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;

  mcdma_top #(.NCH(8), .VERSION(2), .ADDR_W(10)) uut (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .irq(irq)
  );

  function automatic logic [31:0] pat(input logic [31:0] a);
    return a ^ 32'hC3A5_0000;
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= pat(mem_rd_addr);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && mem_wr_en) begin
      wr_count++;
      if (sb_on) begin
        if (sb_q.size() == 0) check("R2 unexpected write", mem_wr_addr, 32'hFFFF_FFFF);
        else begin
          item_t it;
          it = sb_q.pop_front();
          compared++;
          if (mem_wr_addr !== it.addr || mem_wr_data !== it.data) begin
            mismatched++;
            $display("FAIL R%0d: actual %h/%h expected %h/%h", it.req,
                     mem_wr_addr, mem_wr_data, it.addr, it.data);
          end
        end
      end
    end
  end

  task automatic push_burst(input logic [31:0] src, input logic [31:0] dst, input int words,
                            input bit sfix, input bit dfix, input int req);
    for (int k = 0; k < words; k++) begin
      item_t it;
      it.addr = dfix ? dst : dst + 32'(4 * k);
      it.data = pat(sfix ? src : src + 32'(4 * k));
      it.req  = req;
      sb_q.push_back(it);
    end
  endtask

  task automatic reg_write(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = 10'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_read(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = 10'(a);
    @(negedge clk);
    reg_rd_en = 1'b0;
    d = reg_rdata;
  endtask

  task automatic start_chan(input int ch, input logic [31:0] src, input logic [31:0] dst,
                            input int len, input int code, input bit sfix, input bit dfix,
                            input bit ien);
    reg_write(ch * 16 + 0, src);
    reg_write(ch * 16 + 4, dst);
    reg_write(ch * 16 + 8, {16'(len), 8'h00, sfix, dfix, 3'(code), ien, 1'b1, 1'b0});
  endtask

  task automatic drain(input string tag);
    int t = 0;
    while (sb_q.size() != 0 && t < 4000) begin
      @(negedge clk);
      t++;
    end
    check(tag, 32'(sb_q.size()), 32'd0);
    repeat (6) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int n;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R11 reset state
    check("R11 irq", 32'(irq), 0);
    check("R11 mem_wr_en", 32'(mem_wr_en), 0);
    check("R11 mem_rd_en", 32'(mem_rd_en), 0);
    reg_read('h08, d); check("R11 cw0", d, 0);
    reg_read('h204, d); check("R11 done", d, 0);
    reg_read('h200, d); check("R11 unmask", d, 0);
    reg_read('h220, d); check("R9 global after reset", d, 32'h4);

    // R1 register map and readback
    reg_write('h50, 32'h1234_5678);
    reg_write('h54, 32'h9ABC_DEF0);
    reg_write('h58, 32'h0040_FF38);
    reg_write('h5C, 32'hDEAD_BEEF);
    reg_read('h50, d); check("R1 src", d, 32'h1234_5678);
    reg_read('h54, d); check("R1 dst", d, 32'h9ABC_DEF0);
    reg_read('h58, d); check("R1 cw0 idle", d, 32'h0040_FF38);
    reg_read('h5C, d); check("R1 cw1", d, 32'hDEAD_BEEF);
    reg_write('h58, 32'h0);

    // R2 R3 R4 incrementing copy, 6 words in bursts of 4 then 2
    push_burst(32'h1000, 32'h2000, 6, 0, 0, 2);
    start_chan(1, 32'h1000, 32'h2000, 24, 2, 0, 0, 0);
    drain("R2 basic copy drained");
    reg_read('h18, d); check("R5 cw0 after finish", d, 32'h0000_0010);
    reg_read('h10, d); check("R2 src advanced", d, 32'h1018);
    reg_read('h14, d); check("R2 dst advanced", d, 32'h2018);

    // R2 held source, then held destination
    push_burst(32'h3000, 32'h4000, 3, 1, 0, 2);
    start_chan(2, 32'h3000, 32'h4000, 12, 0, 1, 0, 0);
    drain("R2 src hold drained");
    reg_read('h20, d); check("R2 src held", d, 32'h3000);
    push_burst(32'h5000, 32'h6000, 2, 0, 1, 2);
    start_chan(3, 32'h5000, 32'h6000, 8, 1, 0, 1, 0);
    drain("R2 dst hold drained");
    reg_read('h34, d); check("R2 dst held", d, 32'h6000);

    // R3 R4 22 bytes: 5 words in bursts 2,2,1; 2 bytes left behind
    push_burst(32'h7000, 32'h8000, 5, 0, 0, 4);
    start_chan(4, 32'h7000, 32'h8000, 22, 1, 0, 0, 0);
    drain("R4 short final burst drained");
    reg_read('h48, d); check("R3 residual count", d, 32'h0002_0008);

    // R5 count below 4: completes, no data
    start_chan(6, 32'h9000, 32'hA000, 3, 0, 0, 0, 0);
    repeat (10) @(negedge clk);
    check("R5 no write for short count", 32'(sb_q.size()), 0);
    reg_read('h68, d); check("R5 short count cw0", d, 32'h0003_0000);
    reg_read('h204, d); check("R5 done bits", d, 32'h5E);

    // R6 write-one-to-clear
    reg_write('h204, 32'h06);
    reg_read('h204, d); check("R6 clear 1,2", d, 32'h58);
    reg_write('h204, 32'h00);
    reg_read('h204, d); check("R6 zero write keeps", d, 32'h58);

    // R7 interrupt gating
    reg_write('h200, 32'h40);
    repeat (2) @(negedge clk);
    check("R7 irq needs channel enable", 32'(irq), 0);
    push_burst(32'hB000, 32'hC000, 1, 0, 0, 7);
    start_chan(7, 32'hB000, 32'hC000, 4, 0, 0, 0, 1);
    drain("R7 ch7 drained");
    check("R7 irq masked", 32'(irq), 0);
    reg_write('h200, 32'hC0);
    repeat (2) @(negedge clk);
    check("R7 irq raised", 32'(irq), 1);
    reg_write('h204, 32'h80);
    repeat (2) @(negedge clk);
    check("R7 irq dropped", 32'(irq), 0);
    reg_write('h204, 32'hFF);

    // R8 fixed priority: ch2 burst, ch0 x2, ch1 x2, ch2 burst
    push_burst(32'h1_0000, 32'h2_0000, 16, 0, 0, 8);
    push_burst(32'h3_0000, 32'h4_0000, 8, 0, 0, 8);
    push_burst(32'h5_0000, 32'h6_0000, 4, 0, 1, 8);
    push_burst(32'h1_0040, 32'h2_0040, 16, 0, 0, 8);
    start_chan(2, 32'h1_0000, 32'h2_0000, 128, 4, 0, 0, 0);
    start_chan(0, 32'h3_0000, 32'h4_0000, 32, 2, 0, 0, 0);
    start_chan(1, 32'h5_0000, 32'h6_0000, 16, 1, 0, 1, 0);
    drain("R8 fixed order drained");

    // R8 R9 round-robin
    reg_write('h220, 32'h1);
    reg_read('h220, d); check("R9 global rr", d, 32'h5);
    push_burst(32'h1_0000, 32'h2_0000, 16, 0, 0, 8);
    push_burst(32'h3_0000, 32'h4_0000, 4, 0, 0, 8);
    push_burst(32'h5_0000, 32'h6_0000, 2, 0, 1, 8);
    push_burst(32'h1_0040, 32'h2_0040, 16, 0, 0, 8);
    push_burst(32'h3_0010, 32'h4_0010, 4, 0, 0, 8);
    push_burst(32'h5_0008, 32'h6_0000, 2, 0, 1, 8);
    start_chan(2, 32'h1_0000, 32'h2_0000, 128, 4, 0, 0, 0);
    start_chan(0, 32'h3_0000, 32'h4_0000, 32, 2, 0, 0, 0);
    start_chan(1, 32'h5_0000, 32'h6_0000, 16, 1, 0, 1, 0);
    drain("R8 round-robin order drained");
    reg_write('h204, 32'hFF);

    // R10 stop mid-transfer
    sb_on = 1'b0;
    n = wr_count;
    start_chan(5, 32'hD_0000, 32'hE_0000, 400, 4, 0, 0, 0);
    repeat (20) @(negedge clk);
    reg_write('h58, 32'h0);
    repeat (3) @(negedge clk);
    check("R10 some words moved", 32'(wr_count > n), 1);
    n = wr_count;
    repeat (60) @(negedge clk);
    check("R10 no writes after stop", 32'(wr_count), 32'(n));
    reg_read('h58, d); check("R10 cw0 stopped", d, 0);
    reg_read('h204, d); check("R10 no done", d, 0);
    sb_on = 1'b1;
    push_burst(32'hF000, 32'hF800, 2, 0, 0, 10);
    start_chan(0, 32'hF000, 32'hF800, 8, 3, 0, 0, 0);
    drain("R10 engine recovers");
    reg_read('h204, d); check("R10 done after recovery", d, 32'h01);

    finish_run();
  end

endmodule